// File: doc/BRIEF.md
# Bit-serial binary-field multiplier

This block multiplies two elements of GF(2^m) in polynomial basis and returns the product reduced modulo a fixed irreducible polynomial P(x) of degree m. The field size and the low m coefficients of P(x) are elaboration parameters. The leading x^m term is never stored. Each overflow out of the accumulator's top bit stands for that term.

A caller waits for `ready_o`, then pulses `start_i` with both operands. The block takes one bit of the second operand per clock, most significant bit first. Each step shifts the accumulator up by one degree, adds the first operand when the bit is set, and folds the overflowed x^m coefficient back in by XOR with the stored polynomial. The reduction is therefore never a separate pass. After m steps the reduced product is latched on `result_o` and `done_o` pulses once.

Top module: `gf2m_serial_mul`

## Requirements
- R1: `result_o` equals A(x)·B(x) mod P(x), where field addition is bitwise XOR and bit i of a vector is the coefficient of x^i. P(x) is x^M plus the polynomial in parameter `POLY_LOW`; the default is M=233 with P(x)=x^233+x^74+1.
- R2: `done_o` rises exactly M+1 clock edges after the edge that accepted a start, with `result_o` valid in that same cycle.
- R3: A start is accepted on an edge where `start_i` and `ready_o` are both 1. `ready_o` is 0 from that edge until the edge that raises `done_o`, and is 1 again in the done cycle.
- R4: `start_i` while `ready_o` is 0 is ignored. The running product, its latency and its result are unaffected, and no extra completion follows.
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: `result_o` holds its value from one completion until the next completion.
- R7: After reset `ready_o` is 1, `done_o` is 0 and `result_o` is all zeros.
- R8: A zero operand gives a zero result, and multiplying by the element 1 returns the other operand unchanged.
- R9: A start may be accepted in the same cycle that `done_o` is high, giving back-to-back products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a product; taken only when ready_o is 1 |
| a_i | input | M | First operand, sampled at accept |
| b_i | input | M | Second operand, scanned from its top bit, sampled at accept |
| ready_o | output | 1 | Block is idle and will accept a start |
| result_o | output | M | Reduced product of the last completed run |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The operand 0 shows that no stray state carries over from the previous run. The element 1 shows that A enters at the correct step and is shifted the correct number of times without any reduction. All-ones operands force an overflow at nearly every step, so they expose wrong polynomial taps or a missing fold. Random operands check the full multiply-and-reduce against a separately computed carry-less product that is reduced afterwards. Starts raised during a run, and starts issued in the done cycle, show whether the handshake drops or admits requests at the right times.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;
  localparam int unsigned MAX_M = 256;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/gf2m_bit_ctrl.sv
module gf2m_bit_ctrl
  import gf2m_mul_pkg::*;
#(
  parameter int unsigned M = 233
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(M + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(M);

  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o && (cnt_q != LAST);
  assign fin_o  = busy_o && (cnt_q == LAST);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (fin_o) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cnt_q == '0));
  assert_ignore_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
  assert_finish_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == LAST) |=> (!busy_o && done_o));
endmodule

// File: rtl/gf2m_reduce_step.sv
module gf2m_reduce_step #(
  parameter int unsigned     M        = 233,
  parameter logic [M-1:0]    POLY_LOW = M'(1)
) (
  input  logic [M-1:0] acc_i,
  input  logic [M-1:0] a_i,
  input  logic         bit_i,
  output logic [M-1:0] acc_o
);
  logic [M-1:0] shifted;
  logic         ovf;

  // x^M coefficient leaving the top; folded back through P's low terms
  assign ovf     = acc_i[M-1];
  assign shifted = {acc_i[M-2:0], 1'b0};
  assign acc_o   = shifted ^ (a_i & {M{bit_i}}) ^ (POLY_LOW & {M{ovf}});
endmodule

// File: rtl/gf2m_mul_dp.sv
module gf2m_mul_dp #(
  parameter int unsigned  M        = 233,
  parameter logic [M-1:0] POLY_LOW = M'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         fin_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] result_o
);
  logic [M-1:0] a_q, b_q, acc_q, res_q, acc_nxt;

  gf2m_reduce_step #(.M(M), .POLY_LOW(POLY_LOW)) u_step (
    .acc_i (acc_q),
    .a_i   (a_q),
    .bit_i (b_q[M-1]),
    .acc_o (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (load_i) begin
        a_q   <= a_i;
        b_q   <= b_i;
        acc_q <= '0;
      end else if (step_i) begin
        b_q   <= {b_q[M-2:0], 1'b0};
        acc_q <= acc_nxt;
      end
      if (fin_i) res_q <= acc_q;
    end
  end

  assign result_o = res_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(result_o));
  assert_operands_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(a_q) && $stable(acc_q)));
endmodule

// File: rtl/gf2m_serial_mul.sv
module gf2m_serial_mul
  import gf2m_mul_pkg::*;
#(
  parameter int unsigned  M        = 233,
  parameter logic [M-1:0] POLY_LOW = M'(1) | (M'(1) << 74)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         ready_o,
  output logic [M-1:0] result_o,
  output logic         done_o
);
  logic load, step, fin, busy;

  gf2m_bit_ctrl #(.M(M)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  gf2m_mul_dp #(.M(M), .POLY_LOW(POLY_LOW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .fin_i    (fin),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o)
  );

  assign ready_o = !busy;

  assert_ready_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  assert_max_m_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (M <= MAX_M));
endmodule

// File: tb/gf2m_serial_mul_tb.sv
module gf2m_serial_mul_tb;
  localparam int unsigned M       = 233;
  localparam int unsigned CLK_PER = 10;
  localparam int unsigned WDOG    = 200000;
  localparam logic [M-1:0] POLY_LOW = M'(1) | (M'(1) << 74);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [M-1:0] a_i = '0, b_i = '0, result_o;
  logic ready_o, done_o;

  gf2m_serial_mul #(.M(M), .POLY_LOW(POLY_LOW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .ready_o(ready_o), .result_o(result_o), .done_o(done_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    logic [M-1:0] res;
    int           acc_cyc;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, cyc = 0, n_push = 0, n_done = 0;
  logic prev_done = 1'b0;
  logic [M-1:0] last_res = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [M-1:0] model(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-1:0] p, pf;
    p  = '0;
    pf = {{(M-1){1'b0}}, 1'b1, POLY_LOW};
    for (int i = 0; i < M; i++) if (b[i]) p ^= ({{M{1'b0}}, a} << i);
    for (int d = 2*M-2; d >= int'(M); d--) if (p[d]) p ^= (pf << (d - M));
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [M-1:0] v;
    for (int i = 0; i < M; i++) v[i] = 1'($urandom & 1);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // driver: waits for ready, drives one start, pushes the expected item
  task automatic do_mul(input logic [M-1:0] a, input logic [M-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    start_i = 1'b1; a_i = a; b_i = b;
    @(posedge clk); #1;
    e.res = model(a, b); e.acc_cyc = cyc; e.tag = tag;
    exp_q.push_back(e); n_push++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_done && done_o) check(1'b0, "R5", "done longer than one cycle", '0, '0);
      if (done_o && !prev_done) begin
        n_done++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "completion with no accepted start", result_o, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(result_o == e.res, "R1", e.tag, result_o, e.res);
          check(cyc == e.acc_cyc + int'(M) + 1, "R2", "latency",
                M'(cyc - e.acc_cyc), M'(M + 1));
          check(ready_o, "R3", "ready in done cycle", M'(ready_o), M'(1));
          last_res = result_o;
        end
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [M-1:0] x, ones;
    ones = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check(ready_o == 1'b1, "R7", "ready after reset", M'(ready_o), M'(1));
    check(done_o == 1'b0, "R7", "done after reset", M'(done_o), '0);
    check(result_o == '0, "R7", "result after reset", result_o, '0);
    rst_ni = 1'b1;

    // R8 boundaries
    x = rnd();
    do_mul(x, M'(1), "R8 a*1");
    do_mul(M'(0), x, "R8 0*b");
    do_mul(x, M'(0), "R8 a*0");
    do_mul(M'(1), M'(1), "R8 1*1");
    // R1 heavy reduction
    do_mul(ones, ones, "R1 ones*ones");
    do_mul(ones, M'(1) << (M-1), "R1 ones*x^(m-1)");

    // R3 ready low mid-run, R4 start while busy ignored
    do_mul(rnd(), rnd(), "R4 first operands kept");
    repeat (5) @(negedge clk);
    check(ready_o == 1'b0, "R3", "ready low while busy", M'(ready_o), '0);
    start_i = 1'b1; a_i = ones; b_i = ones;
    repeat (10) @(negedge clk);
    start_i = 1'b0;
    while (!ready_o) @(negedge clk);
    repeat (M + 5) @(negedge clk);
    check(n_done == n_push, "R4", "no extra completion", M'(n_done), M'(n_push));

    // R6 result holds while idle
    repeat (20) @(negedge clk);
    check(result_o == last_res, "R6", "result held", result_o, last_res);

    // R9 back-to-back: start in the done cycle
    do_mul(rnd(), rnd(), "R9 first");
    @(negedge clk);
    while (!done_o) @(negedge clk);
    start_i = 1'b1; a_i = ones; b_i = M'(3);
    begin
      exp_t e;
      @(posedge clk); #1;
      e.res = model(ones, M'(3)); e.acc_cyc = cyc; e.tag = "R9 second";
      exp_q.push_back(e); n_push++;
    end
    @(negedge clk);
    start_i = 1'b0;
    check(ready_o == 1'b0, "R9", "accepted in done cycle", M'(ready_o), '0);

    // R1 random
    for (int k = 0; k < 12; k++) do_mul(rnd(), rnd(), "R1 random");

    @(negedge clk);
    while (!ready_o || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_done == n_push, "R5", "one done per start", M'(n_done), M'(n_push));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule